// File: doc/BRIEF.md
# Erase Status Toggle Generator

This block forms the status byte that a parallel flash device returns on reads while a sector erase is running or paused. It keeps two toggle registers that carry complementary information. The mode toggle, on bit 6, changes on every status read while the erase is actively running and stays fixed while the erase is suspended. It does not depend on which sector is addressed. The sector toggle, on bit 2, changes on every read that addresses a sector marked for erasure. It behaves the same in both modes, so it shows which sectors are involved but not whether the erase is running. Software reads both bits to learn the mode and the sector selection.

Status becomes valid only at the pulse that marks the rising edge of the last write of the erase command. That pulse clears both toggles and arms the block. A read is complete when either the output-enable strobe or the chip-enable strobe reports completion. Both arrive as one-cycle pulses already synchronised to `clk`. The erase sequencer supplies the mode flags and the per-sector selection mask.

Top module: `erase_toggle_status`

## Requirements
- R1: After reset, `statusByte` is 8'h00 and `statusValid` is 0.
- R2: A `finalWrite` pulse sets `statusValid` to 1 and clears bit 6 and bit 2 of `statusByte` on the next cycle. It takes priority over a read in the same cycle.
- R3: While `statusValid` is 1, `eraseActive` is 1 and `eraseSuspend` is 0, each completed read inverts bit 6 of `statusByte` on the next cycle.
- R4: While `eraseSuspend` is 1, reads leave bit 6 unchanged. This holds even when `eraseActive` is also 1.
- R5: While `statusValid` is 1 and either mode flag is 1, a completed read whose `readSector` value i has `eraseMask[i]` set inverts bit 2 on the next cycle. This applies equally in active and suspended mode.
- R6: A read at a sector whose mask bit is 0, or whose index is not below NUM_SECTORS, leaves bit 2 unchanged.
- R7: A pulse on `oeReadDone` or on `ceReadDone` completes a read. Pulses on both in the same cycle count as one read.
- R8: While `statusValid` is 0, `statusByte` reads 8'h00 and reads change nothing visible.
- R9: One cycle after both `eraseActive` and `eraseSuspend` are 0 (with no `finalWrite`), `statusValid` is 0.
- R10: Bits 7, 5, 4, 3, 1 and 0 of `statusByte` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| oeReadDone | input | 1 | Read completed, delimited by output enable |
| ceReadDone | input | 1 | Read completed, delimited by chip enable |
| readSector | input | SECT_W | Sector index decoded from the read address |
| eraseMask | input | NUM_SECTORS | Bit i set means sector i is selected for erase |
| eraseActive | input | 1 | Erase algorithm running |
| eraseSuspend | input | 1 | Erase paused |
| finalWrite | input | 1 | Pulse at the rising edge of the last command write |
| statusByte | output | 8 | Status byte: bit 6 mode toggle, bit 2 sector toggle |
| statusValid | output | 1 | Toggle status is valid |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it. Both toggles and the valid flag are single registers, and the output byte is a plain view of them. The bench applies inputs on the falling edge. It advances its own model for that same cycle and compares the ports at the following falling edge, once the rising edge has been processed. This way each check sees the outcome of exactly one cycle of stimulus.

// File: rtl/erase_toggle_pkg.sv
package erase_toggle_pkg;
  localparam int unsigned MODE_BIT = 6;
  localparam int unsigned SECT_BIT = 2;

  typedef struct packed {
    logic clearTog;
    logic flipMode;
    logic flipSectEn;
    logic armed;
  } togStrobes_t;
endpackage

// File: rtl/erase_toggle_ctrl.sv
module erase_toggle_ctrl
  import erase_toggle_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        oeReadDone,
  input  logic        ceReadDone,
  input  logic        eraseActive,
  input  logic        eraseSuspend,
  input  logic        finalWrite,
  output togStrobes_t strobes
);
  logic armedQ;
  logic readEvt;
  logic inErase;

  always_comb begin
    readEvt = oeReadDone | ceReadDone;
    inErase = eraseActive | eraseSuspend;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armedQ <= 1'b0;
    end else if (finalWrite) begin
      armedQ <= 1'b1;
    end else if (!inErase) begin
      armedQ <= 1'b0;
    end
  end

  always_comb begin
    strobes.armed      = armedQ;
    strobes.clearTog   = finalWrite;
    strobes.flipMode   = !finalWrite && armedQ && readEvt && eraseActive && !eraseSuspend;
    strobes.flipSectEn = !finalWrite && armedQ && readEvt && inErase;
  end
endmodule

// File: rtl/erase_toggle_dp.sv
module erase_toggle_dp
  import erase_toggle_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 128,
  localparam int unsigned SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  togStrobes_t            strobes,
  input  logic [SECT_W-1:0]      readSector,
  input  logic [NUM_SECTORS-1:0] eraseMask,
  output logic [7:0]             statusByte
);
  logic [NUM_SECTORS-1:0] sectHit;
  logic selHit;
  logic modeTogQ;
  logic sectTogQ;

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_match
    assign sectHit[i] = eraseMask[i] && (readSector == SECT_W'(i));
  end

  assign selHit = |sectHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeTogQ <= 1'b0;
      sectTogQ <= 1'b0;
    end else if (strobes.clearTog) begin
      modeTogQ <= 1'b0;
      sectTogQ <= 1'b0;
    end else begin
      if (strobes.flipMode) begin
        modeTogQ <= !modeTogQ;
      end
      if (strobes.flipSectEn && selHit) begin
        sectTogQ <= !sectTogQ;
      end
    end
  end

  always_comb begin
    statusByte = 8'h00;
    statusByte[MODE_BIT] = strobes.armed && modeTogQ;
    statusByte[SECT_BIT] = strobes.armed && sectTogQ;
  end
endmodule

// File: rtl/erase_toggle_status.sv
module erase_toggle_status
  import erase_toggle_pkg::*;
#(
  parameter int unsigned NUM_SECTORS = 128,
  localparam int unsigned SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   oeReadDone,
  input  logic                   ceReadDone,
  input  logic [SECT_W-1:0]      readSector,
  input  logic [NUM_SECTORS-1:0] eraseMask,
  input  logic                   eraseActive,
  input  logic                   eraseSuspend,
  input  logic                   finalWrite,
  output logic [7:0]             statusByte,
  output logic                   statusValid
);
  togStrobes_t strobes;

  erase_toggle_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .oeReadDone   (oeReadDone),
    .ceReadDone   (ceReadDone),
    .eraseActive  (eraseActive),
    .eraseSuspend (eraseSuspend),
    .finalWrite   (finalWrite),
    .strobes      (strobes)
  );

  erase_toggle_dp #(.NUM_SECTORS(NUM_SECTORS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .readSector (readSector),
    .eraseMask  (eraseMask),
    .statusByte (statusByte)
  );

  assign statusValid = strobes.armed;
endmodule

// File: rtl/erase_toggle_status_chk.sv
module erase_toggle_status_chk #(
  parameter int unsigned NUM_SECTORS = 128,
  localparam int unsigned SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   oeReadDone,
  input logic                   ceReadDone,
  input logic [SECT_W-1:0]      readSector,
  input logic [NUM_SECTORS-1:0] eraseMask,
  input logic                   eraseActive,
  input logic                   eraseSuspend,
  input logic                   finalWrite,
  input logic [7:0]             statusByte,
  input logic                   statusValid
);
  logic rd;
  logic selNow;

  always_comb begin
    rd = oeReadDone | ceReadDone;
    selNow = 1'b0;
    for (int i = 0; i < NUM_SECTORS; i++) begin
      if (readSector == SECT_W'(i) && eraseMask[i]) selNow = 1'b1;
    end
  end

  // R2
  final_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    finalWrite |=> (statusValid && statusByte[6] == 1'b0 && statusByte[2] == 1'b0));

  // R3
  mode_flips_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && rd && eraseActive && !eraseSuspend && !finalWrite)
      |=> (statusByte[6] != $past(statusByte[6])));

  // R4
  suspend_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && eraseSuspend && !finalWrite) |=> $stable(statusByte[6]));

  // R6
  unselected_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && !selNow && !finalWrite && (eraseActive || eraseSuspend))
      |=> $stable(statusByte[2]));

  // R8
  invalid_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> (statusByte == 8'h00));

  // R9
  disarm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!eraseActive && !eraseSuspend && !finalWrite) |=> !statusValid);

  // R10
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte & 8'hBB) == 8'h00);
endmodule

bind erase_toggle_status erase_toggle_status_chk #(.NUM_SECTORS(NUM_SECTORS)) u_chk (.*);

// File: tb/erase_toggle_status_bench.sv
module erase_toggle_status_bench;
  localparam int unsigned NUM_SECTORS = 128;
  localparam int unsigned SECT_W = $clog2(NUM_SECTORS);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oeReadDone = 1'b0;
  logic ceReadDone = 1'b0;
  logic [SECT_W-1:0] readSector = '0;
  logic [NUM_SECTORS-1:0] eraseMask = '0;
  logic eraseActive = 1'b0;
  logic eraseSuspend = 1'b0;
  logic finalWrite = 1'b0;
  logic [7:0] statusByte;
  logic statusValid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic mValid = 1'b0;
  logic mMode = 1'b0;
  logic mSect = 1'b0;

  always #10 clk = !clk;

  erase_toggle_status #(.NUM_SECTORS(NUM_SECTORS)) u_erase_toggle_status (
    .clk(clk), .rstN(rstN), .oeReadDone(oeReadDone), .ceReadDone(ceReadDone),
    .readSector(readSector), .eraseMask(eraseMask), .eraseActive(eraseActive),
    .eraseSuspend(eraseSuspend), .finalWrite(finalWrite),
    .statusByte(statusByte), .statusValid(statusValid)
  );

  function automatic logic [7:0] expByte(logic v, logic m, logic s);
    logic [7:0] b = 8'h00;
    if (v) begin
      b[6] = m;
      b[2] = s;
    end
    return b;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance the model for the inputs now applied (spec R2-R9)
  task automatic modelStep();
    logic rd = oeReadDone | ceReadDone;
    logic sel = eraseMask[readSector];
    if (finalWrite) begin
      mValid = 1'b1; mMode = 1'b0; mSect = 1'b0;
    end else begin
      if (mValid && rd && eraseActive && !eraseSuspend) mMode = !mMode;
      if (mValid && rd && (eraseActive || eraseSuspend) && sel) mSect = !mSect;
      if (!eraseActive && !eraseSuspend) mValid = 1'b0;
    end
  endtask

  task automatic cycle(string req);
    modelStep();
    @(negedge clk);
    check({req, " byte"}, 32'(statusByte), 32'(expByte(mValid, mMode, mSect)));
    check({req, " valid"}, 32'(statusValid), 32'(mValid));
    check("R10 spare", 32'(statusByte & 8'hBB), 32'h0);
  endtask

  task automatic idle();
    oeReadDone = 0; ceReadDone = 0; finalWrite = 0;
  endtask

  initial begin
    #4_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    // R1
    check("R1 byte", 32'(statusByte), 32'h0);
    check("R1 valid", 32'(statusValid), 32'h0);
    rstN = 1'b1;

    // R8: reads before arming leave the byte at zero
    eraseActive = 1; eraseMask = '1;
    oeReadDone = 1; readSector = 7'd3;
    cycle("R8 unarmed read");
    idle();

    // R2: arm while a read also arrives
    eraseMask = '0; eraseMask[5] = 1'b1; eraseMask[127] = 1'b1;
    finalWrite = 1; oeReadDone = 1; readSector = 7'd5;
    cycle("R2 arm");
    idle();

    // R3, R5: active erase, selected sector, both bits flip
    oeReadDone = 1; readSector = 7'd5;
    cycle("R3 R5 active sel");
    // R6: unselected sector holds bit 2
    readSector = 7'd6;
    cycle("R6 unselected");
    // R7: chip-enable alone, then both together counted once
    oeReadDone = 0; ceReadDone = 1; readSector = 7'd127;
    cycle("R7 ce read");
    oeReadDone = 1;
    cycle("R7 both strobes");
    // R4: suspend with active still set, bit 6 holds, bit 2 flips
    eraseSuspend = 1;
    cycle("R4 R5 suspend");
    eraseActive = 0;
    cycle("R4 suspend only");
    idle();
    // R2: re-arm clears toggles
    finalWrite = 1;
    cycle("R2 rearm");
    idle();
    // R9: both flags low disarms
    eraseSuspend = 0;
    cycle("R9 disarm");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 99));
      finalWrite   = (r < 4);
      oeReadDone   = ($urandom_range(0, 1) == 1);
      ceReadDone   = ($urandom_range(0, 3) == 0);
      readSector   = SECT_W'($urandom);
      eraseActive  = ($urandom_range(0, 9) != 0);
      eraseSuspend = ($urandom_range(0, 3) == 0);
      if (n % 200 == 0) begin
        for (int w = 0; w < NUM_SECTORS / 32; w++) eraseMask[w*32 +: 32] = $urandom;
      end
      cycle("R3 R4 R5 R6 R7 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule